// File: doc/BRIEF.md
# Ping-Pong Bulk Packet Buffer

This block decouples a packet-oriented USB bulk endpoint from a disk-side data engine. It holds two equal banks, each large enough for one maximum-size bulk packet. While the producer fills one bank, the consumer drains the other. When a bank is complete it passes to the consumer, and the producer moves on to the other bank. Two instances are used per device: one for each bulk direction. In the bulk-IN direction the disk engine writes and the USB engine reads. In the bulk-OUT direction the roles are reversed. Control endpoint traffic uses a separate buffer.

A bank is complete when its byte count reaches the payload limit for the current bus speed: 64 bytes at full speed and 512 at high speed. A bank is also complete earlier when the producer marks a byte as the end of a transfer, and such a packet is reported as short. At handover the bank's byte count is latched, so the consumer can read the packet length before it takes any data. A synchronous flush discards both banks.

The speed input is assumed to change only while both banks are empty and no packet is being filled. Bank size is assumed to be a power of two.

Top module: `pp_pkt_buffer`

## Requirements
- R1: After reset, `wr_ready` is 1 and `rd_valid` is 0.
- R2: With `high_speed` = 0, a bank is handed over on the byte that brings its count to `FS_LIMIT`. With `high_speed` = 1, the handover happens at `HS_LIMIT`. In both cases `rd_count` equals the limit and `rd_short` is 0, and before that byte `rd_valid` stays 0.
- R3: A byte accepted with `wr_last` = 1 hands its bank over at once. `rd_count` is then the number of bytes written, including that byte, and `rd_short` is 1.
- R4: The consumer receives the bytes of a bank in write order. `rd_last` is 1 only on the final byte of the bank.
- R5: `wr_ready` is 0 exactly when both banks are owned by the consumer.
- R6: Banks are delivered to the consumer in the order in which they were filled.
- R7: `rd_valid` rises in the cycle after the handover byte is accepted. While a bank is presented, `rd_count` and `rd_short` hold until that bank's last byte is taken.
- R8: When `flush` is 1 at a clock edge, after that edge both banks are empty: `rd_valid` is 0 and `wr_ready` is 1. The next packet then starts at byte 0 of a fresh bank.
- R9: The producer can fill one bank in the same cycles in which the consumer drains the other, with no loss or reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard both banks |
| high_speed | input | 1 | 1 selects the high-speed payload limit |
| wr_valid | input | 1 | Producer byte valid |
| wr_ready | output | 1 | Producer may write |
| wr_data | input | DATA_W | Producer byte |
| wr_last | input | 1 | Byte ends the transfer (short packet) |
| rd_valid | output | 1 | A completed bank is presented; data valid |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_data | output | DATA_W | Consumer byte |
| rd_last | output | 1 | Final byte of the presented bank |
| rd_count | output | CNT_W | Byte count of the presented bank |
| rd_short | output | 1 | Presented bank ended early by `wr_last` |

## Verification
The bench builds the buffer with 32-byte banks, a full-speed limit of 8 and a high-speed limit of 32. These values keep the stall case, which needs two full packets, and the full-bank boundary at high speed within a few dozen cycles each. The mode switch can therefore be exercised in both directions. With the smaller limits, the bench can also overlap filling and draining, and can flush both banks while they are full, without long runs.

// File: rtl/ppbuf_pkg.sv
// Package: shared helpers for the ping-pong packet buffer.
// Assumes limits fit in a 32-bit unsigned value.
package ppbuf_pkg;

    // Select the payload limit for the current bus speed.
    function automatic int unsigned pick_limit(input logic hs,
                                               input int unsigned fs_lim,
                                               input int unsigned hs_lim);
        return hs ? hs_lim : fs_lim;
    endfunction

endpackage

// File: rtl/ppbuf_store.sv
// Storage for the two banks. One write port addressed by bank and offset,
// one asynchronous read port addressed the same way.
// Assumes the writer never writes the bank the reader is presenting.
module ppbuf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 512,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] bank_word [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DATA_W-1:0] cells [DEPTH];

        // Write a byte into this bank when it is the selected target.
        always_ff @(posedge clk) begin
            if (we && (wbank == b[0])) begin
                cells[waddr] <= wdata;
            end
        end

        assign bank_word[b] = cells[raddr];
    end

    assign rdata = bank_word[rbank];

endmodule

// File: rtl/ppbuf_fill.sv
// Producer side: tracks the bank being filled and its byte offset, and
// raises a handover when the limit is reached or the transfer ends.
// Assumes the limit does not shrink below the current offset mid-packet.
module ppbuf_fill #(
    parameter int DEPTH = 512,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CNT_W-1:0] limit,
    input  logic [1:0]       bank_full,
    input  logic             wr_valid,
    input  logic             wr_last,
    output logic             wr_ready,
    output logic             mem_we,
    output logic             mem_bank,
    output logic [PTR_W-1:0] mem_addr,
    output logic             hand_go,
    output logic             hand_bank,
    output logic [CNT_W-1:0] hand_cnt,
    output logic             hand_short
);

    logic             fill_bank;
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] next_cnt;
    logic             accept;

    // Decode acceptance and completion of the current bank.
    always_comb begin
        wr_ready   = !bank_full[fill_bank];
        accept     = wr_valid && wr_ready;
        next_cnt   = fill_cnt + 1'b1;
        hand_go    = accept && (wr_last || (next_cnt >= limit));
        hand_bank  = fill_bank;
        hand_cnt   = next_cnt;
        hand_short = next_cnt < limit;
        mem_we     = accept;
        mem_bank   = fill_bank;
        mem_addr   = fill_cnt[PTR_W-1:0];
    end

    // Advance the offset, or swap banks on handover.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            fill_bank <= 1'b0;
            fill_cnt  <= '0;
        end else if (hand_go) begin
            fill_bank <= !fill_bank;
            fill_cnt  <= '0;
        end else if (accept) begin
            fill_cnt  <= next_cnt;
        end
    end

endmodule

// File: rtl/ppbuf_drain.sv
// Consumer side: presents the next owned bank, walks its bytes and
// releases it after the final byte is taken.
// Assumes a presented bank holds at least one byte.
module ppbuf_drain #(
    parameter int DEPTH = 512,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             cur_full,
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic             rd_ready,
    output logic             drain_bank,
    output logic             rd_valid,
    output logic             rd_last,
    output logic [PTR_W-1:0] rd_addr,
    output logic             release_go
);

    logic [CNT_W-1:0] drain_ptr;
    logic [CNT_W-1:0] ptr_nxt;

    // Present the bank and flag its final byte.
    always_comb begin
        ptr_nxt    = drain_ptr + 1'b1;
        rd_valid   = cur_full;
        rd_last    = cur_full && (ptr_nxt == cur_cnt);
        rd_addr    = drain_ptr[PTR_W-1:0];
        release_go = rd_valid && rd_ready && rd_last;
    end

    // Step through the bank, then move to the other one.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            drain_bank <= 1'b0;
            drain_ptr  <= '0;
        end else if (release_go) begin
            drain_bank <= !drain_bank;
            drain_ptr  <= '0;
        end else if (rd_valid && rd_ready) begin
            drain_ptr  <= ptr_nxt;
        end
    end

endmodule

// File: rtl/pp_pkt_buffer.sv
// Top: two-bank ping-pong packet buffer with speed-dependent payload
// limit, short-packet reporting and a one-cycle flush.
// Assumes high_speed changes only while both banks are empty and idle,
// and DEPTH is a power of two no smaller than either limit.
module pp_pkt_buffer #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 512,
    parameter int FS_LIMIT = 64,
    parameter int HS_LIMIT = 512,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              high_speed,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [CNT_W-1:0]  rd_count,
    output logic              rd_short
);
    import ppbuf_pkg::*;

    logic [CNT_W-1:0] limit;
    logic [1:0]       bank_full;
    logic [CNT_W-1:0] bank_cnt [2];
    logic [1:0]       bank_short;

    logic             mem_we, mem_bank;
    logic [PTR_W-1:0] mem_addr, rd_addr;
    logic             hand_go, hand_bank, hand_short;
    logic [CNT_W-1:0] hand_cnt;
    logic             drain_bank, release_go;

    // Payload limit for the current speed.
    assign limit = CNT_W'(pick_limit(high_speed, FS_LIMIT, HS_LIMIT));

    ppbuf_fill #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .flush(flush), .limit(limit),
        .bank_full(bank_full), .wr_valid(wr_valid), .wr_last(wr_last),
        .wr_ready(wr_ready), .mem_we(mem_we), .mem_bank(mem_bank),
        .mem_addr(mem_addr), .hand_go(hand_go), .hand_bank(hand_bank),
        .hand_cnt(hand_cnt), .hand_short(hand_short)
    );

    ppbuf_drain #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_drain (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cur_full(bank_full[drain_bank]), .cur_cnt(bank_cnt[drain_bank]),
        .rd_ready(rd_ready), .drain_bank(drain_bank), .rd_valid(rd_valid),
        .rd_last(rd_last), .rd_addr(rd_addr), .release_go(release_go)
    );

    ppbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk(clk), .we(mem_we), .wbank(mem_bank), .waddr(mem_addr),
        .wdata(wr_data), .rbank(drain_bank), .raddr(rd_addr), .rdata(rd_data)
    );

    for (genvar b = 0; b < 2; b++) begin : g_own
        // Ownership of this bank: set on handover, cleared on release.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                bank_full[b] <= 1'b0;
            end else if (hand_go && (hand_bank == b[0])) begin
                bank_full[b] <= 1'b1;
            end else if (release_go && (drain_bank == b[0])) begin
                bank_full[b] <= 1'b0;
            end
        end

        // Latch the length and short flag of this bank at handover.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_cnt[b]   <= '0;
                bank_short[b] <= 1'b0;
            end else if (hand_go && (hand_bank == b[0])) begin
                bank_cnt[b]   <= hand_cnt;
                bank_short[b] <= hand_short;
            end
        end
    end

    assign rd_count = bank_cnt[drain_bank];
    assign rd_short = bank_short[drain_bank];

endmodule

// File: rtl/ppbuf_checker.sv
// Checker: temporal properties of the ping-pong buffer ports, bound to
// the top module. Assumes high_speed is stable while a bank is held.
module ppbuf_checker #(
    parameter int CNT_W    = 10,
    parameter int FS_LIMIT = 64,
    parameter int HS_LIMIT = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             high_speed,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic             rd_last,
    input logic [CNT_W-1:0] rd_count
);

    assert_stall_needs_owned_bank_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        !wr_ready |-> rd_valid);

    assert_flush_empties_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        flush |=> (!rd_valid && wr_ready));

    assert_count_in_range_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_count != '0) &&
                      (rd_count <= (high_speed ? CNT_W'(HS_LIMIT) : CNT_W'(FS_LIMIT)))));

    assert_last_within_bank_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    assert_count_held_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_valid && !(rd_ready && rd_last) && !flush) |=> (rd_valid && $stable(rd_count)));

endmodule

bind pp_pkt_buffer ppbuf_checker #(
    .CNT_W(CNT_W), .FS_LIMIT(FS_LIMIT), .HS_LIMIT(HS_LIMIT)
) u_ppbuf_checker (
    .clk(clk), .rst_n(rst_n), .flush(flush), .high_speed(high_speed),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_last(rd_last), .rd_count(rd_count)
);

// File: tb/pp_pkt_buffer_test.sv
`timescale 1ns/1ps
// Directed bench for the ping-pong packet buffer: one task per scenario.
module pp_pkt_buffer_test;
    localparam int DW  = 8;
    localparam int DEP = 32;
    localparam int FSL = 8;
    localparam int HSL = 32;
    localparam int CW  = $clog2(DEP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          high_speed = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [DW-1:0] wr_data = '0;
    logic          wr_last = 1'b0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_last;
    logic [CW-1:0] rd_count;
    logic          rd_short;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pp_pkt_buffer #(.DATA_W(DW), .DEPTH(DEP), .FS_LIMIT(FSL), .HS_LIMIT(HSL)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .high_speed(high_speed),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .wr_last(wr_last), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_last(rd_last), .rd_count(rd_count),
        .rd_short(rd_short)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d, input logic last);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_last = last;
        while (!wr_ready) @(negedge clk);
        @(posedge clk); #1;
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    task automatic push_pkt(input int n, input logic [DW-1:0] seed, input logic end_flag);
        for (int i = 0; i < n; i++) push(seed + DW'(i), end_flag && (i == n - 1));
    endtask

    task automatic pop(output logic [DW-1:0] d, output logic l, output int cnt);
        @(negedge clk);
        rd_ready = 1'b1;
        while (!rd_valid) @(negedge clk);
        d = rd_data; l = rd_last; cnt = int'(rd_count);
        @(posedge clk); #1;
        rd_ready = 1'b0;
    endtask

    // Check header, then every byte, order and last marker of one bank.
    task automatic drain_chk(input string req, input int n, input logic sh, input logic [DW-1:0] seed);
        logic [DW-1:0] d;
        logic l;
        int c;
        @(negedge clk);
        chk({req, " valid"}, int'(rd_valid), 1);
        chk({req, " count"}, int'(rd_count), n);
        chk({req, " short"}, int'(rd_short), int'(sh));
        for (int i = 0; i < n; i++) begin
            pop(d, l, c);
            chk({req, "/R4 data"}, int'(d), int'(seed + DW'(i)));
            chk({req, "/R4 last"}, int'(l), int'(i == n - 1));
            chk("R7 count held", c, n);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wr_ready", int'(wr_ready), 1);
        chk("R1 rd_valid", int'(rd_valid), 0);
    endtask

    task automatic t_full_fs;
        high_speed = 1'b0;
        push_pkt(FSL - 1, 8'h10, 1'b0);
        @(negedge clk);
        chk("R2 not yet handed", int'(rd_valid), 0);
        push(8'h10 + DW'(FSL - 1), 1'b0);
        drain_chk("R2 fs", FSL, 1'b0, 8'h10);
    endtask

    task automatic t_short;
        push_pkt(3, 8'h20, 1'b1);
        drain_chk("R3 short", 3, 1'b1, 8'h20);
    endtask

    task automatic t_hs;
        high_speed = 1'b1;
        push_pkt(HSL - 1, 8'h30, 1'b0);
        @(negedge clk);
        chk("R2 hs not yet handed", int'(rd_valid), 0);
        push(8'h30 + DW'(HSL - 1), 1'b0);
        drain_chk("R2 hs", HSL, 1'b0, 8'h30);
        high_speed = 1'b0;
    endtask

    task automatic t_stall_order;
        push_pkt(FSL, 8'h40, 1'b0);
        @(negedge clk);
        chk("R5 ready one bank held", int'(wr_ready), 1);
        push_pkt(5, 8'h80, 1'b1);
        @(negedge clk);
        chk("R5 stall both held", int'(wr_ready), 0);
        drain_chk("R6 first bank", FSL, 1'b0, 8'h40);
        @(negedge clk);
        chk("R5 ready after release", int'(wr_ready), 1);
        drain_chk("R6 second bank", 5, 1'b1, 8'h80);
    endtask

    task automatic t_overlap;
        push_pkt(FSL, 8'hA0, 1'b0);
        fork
            push_pkt(FSL, 8'hC0, 1'b0);
            drain_chk("R9 drain A", FSL, 1'b0, 8'hA0);
        join
        drain_chk("R9 drain B", FSL, 1'b0, 8'hC0);
    endtask

    task automatic t_flush;
        push_pkt(5, 8'h50, 1'b0);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        chk("R8 partial flush valid", int'(rd_valid), 0);
        push_pkt(3, 8'h60, 1'b1);
        drain_chk("R8 restart", 3, 1'b1, 8'h60);
        push_pkt(FSL, 8'h70, 1'b0);
        push_pkt(FSL, 8'h78, 1'b0);
        @(negedge clk);
        chk("R8 both full before flush", int'(wr_ready), 0);
        flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        chk("R8 full flush valid", int'(rd_valid), 0);
        chk("R8 full flush ready", int'(wr_ready), 1);
        push_pkt(2, 8'h90, 1'b1);
        drain_chk("R8 after full flush", 2, 1'b1, 8'h90);
    endtask

    initial begin
        t_reset;
        t_full_fs;
        t_short;
        t_hs;
        t_stall_order;
        t_overlap;
        t_flush;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule